// File: doc/BRIEF.md
# Debug Access Gate and Mode Controller

This block decides whether a device may enter its debug mode. Out of power-on it is locked. While the external reset pin is held low, a 32-bit key can be clocked in serially on the debug pin using a separate key strobe. When the received word equals the key parameter, the block becomes unlocked. The unlocked condition survives the release of the reset pin.

Once the device is unlocked and the reset pin is released, the serial receiver beside this block runs its baud-rate calibration on the same pin. A success pulse from that calibration moves the block into debug mode. Debug mode ends when software clears the mode bit, or on a watchdog reset, an external reset-pin assertion, a brownout or a power-on reset. A brownout or power-on reset also locks the block again.

The block also watches the debug pin while the core is stopped. If the pin is seen low on two consecutive synchronized samples, it raises a single-cycle system-reset request.

Top module: `debug_access_ctrl`

## Requirements
- R1: While `pin_reset_n` is low, each synchronized rising edge of `key_clk` shifts the synchronized `dbg_pin` level into the key register, most significant bit first. After the 32nd bit the received word is compared with `KEY`, and on a match `unlocked` goes to 1.
- R2: On a mismatch the block stays locked, and the bit count and shift register are cleared, so the next 32 strobes form a fresh attempt.
- R3: Key strobes while `pin_reset_n` is high are ignored. A partly received key is discarded when `pin_reset_n` goes high.
- R4: A `baud_done` pulse while unlocked, not in debug mode and with `pin_reset_n` high sets `dbg_mode` to 1 in the next cycle. `baud_done` has no effect while locked or while `pin_reset_n` is low.
- R5: A `mode_clr` pulse in debug mode sets `dbg_mode` to 0 in the next cycle, and `unlocked` stays 1.
- R6: `wdt_evt` high or `pin_reset_n` low in debug mode sets `dbg_mode` to 0 in the next cycle, and `unlocked` stays 1.
- R7: `bor_evt` high or `rst_n` low sets both `unlocked` and `dbg_mode` to 0 in the next cycle.
- R8: With `stop_mode` high, a low level of the synchronized `dbg_pin` on two consecutive samples produces exactly one single-cycle `sys_rst_req` pulse for each low episode. No pulse is produced for a single-sample low, or while `stop_mode` is low.
- R9: `dbg_mode` is never 1 while `unlocked` is 0, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bor_evt | input | 1 | Brownout reset event, synchronous |
| wdt_evt | input | 1 | Watchdog reset event, synchronous |
| pin_reset_n | input | 1 | Synchronized level of the external reset pin, active low |
| dbg_pin | input | 1 | Raw debug pin level, asynchronous, idles high |
| key_clk | input | 1 | Raw key strobe, asynchronous, rising edge shifts one bit |
| stop_mode | input | 1 | Core is in STOP mode |
| baud_done | input | 1 | Auto-baud calibration success pulse |
| mode_clr | input | 1 | Software write of 0 to the debug-mode bit |
| unlocked | output | 1 | Debug access is unlocked |
| dbg_mode | output | 1 | Device is in debug mode |
| sys_rst_req | output | 1 | Single-cycle system-reset request |

## Verification
A wrong internal state shows up as an output level that does not match the sequence of events applied. Because the state register drives `unlocked` and `dbg_mode` directly, a bad transition is visible one cycle after the triggering pulse. A key shifter with a bad count or a stale partial word makes the correct key fail, or makes a wrong key pass. This is seen within three cycles of the 32nd strobe reaching the synchronizer. A faulty STOP detector shows as a missing, repeated or unexpected `sys_rst_req` pulse within four cycles of the pin level change.

// File: rtl/dbg_access_pkg.sv
// Shared types for the debug access controller.
package dbg_access_pkg;
    // Access states; order has no behavioural meaning.
    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_UNLOCKED = 2'd1,
        ST_DEBUG    = 2'd2
    } acc_state_t;
endpackage

// File: rtl/dbg_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; no bundle coherency is guaranteed.
module dbg_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Pass along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/dbg_key_shift.sv
// Serial key receiver: shifts synchronized data bits MSB first on rising
// strobe edges while armed, compares after KEY_W bits, and pulses key_ok
// on a match. Assumes strobe and data are already synchronized.
module dbg_key_shift #(
    parameter int              KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY  = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic strobe_s,
    input  logic data_s,
    output logic key_ok
);
    localparam int CNT_W = $clog2(KEY_W + 1);

    logic [KEY_W-1:0] shreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             strobe_d;
    logic             edge_w;
    logic             last_w;
    logic [KEY_W-1:0] next_w;

    assign edge_w = strobe_s && !strobe_d;
    assign last_w = (cnt_q == CNT_W'(KEY_W - 1));
    assign next_w = {shreg_q[KEY_W-2:0], data_s};

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe_s;
    end

    // Shift bits, count, and restart after each complete word or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !arm) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            key_ok  <= 1'b0;
        end else if (edge_w) begin
            key_ok <= last_w && (next_w == KEY);
            if (last_w) begin
                shreg_q <= '0;
                cnt_q   <= '0;
            end else begin
                shreg_q <= next_w;
                cnt_q   <= cnt_q + 1'b1;
            end
        end else begin
            key_ok <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_stop_wake.sv
// STOP-mode pin watcher: one-cycle reset request after the synchronized
// pin has been low for two consecutive samples while the core is stopped.
// Re-arms only when the condition goes away.
module dbg_stop_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_mode,
    input  logic pin_s,
    output logic req
);
    logic low_w;
    logic low_q;
    logic held_q;

    assign low_w = stop_mode && !pin_s;

    // Track consecutive low samples and emit a single pulse per episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= 1'b0;
            held_q <= 1'b0;
            req    <= 1'b0;
        end else begin
            low_q  <= low_w;
            held_q <= low_w && low_q;
            req    <= low_w && low_q && !held_q;
        end
    end
endmodule

// File: rtl/dbg_mode_fsm.sv
// Access state machine: locked, unlocked, debug. Brownout and power-on
// reset lock it; watchdog, reset pin and software clear leave debug.
module dbg_mode_fsm
    import dbg_access_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bor_evt,
    input  logic wdt_evt,
    input  logic pin_reset_n,
    input  logic key_ok,
    input  logic baud_done,
    input  logic mode_clr,
    output logic unlocked,
    output logic dbg_mode
);
    acc_state_t state_q;
    acc_state_t state_n;

    // Next-state selection with reset sources taking priority.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_LOCKED:   if (key_ok) state_n = ST_UNLOCKED;
            ST_UNLOCKED: if (pin_reset_n && !wdt_evt && baud_done) state_n = ST_DEBUG;
            ST_DEBUG:    if (wdt_evt || !pin_reset_n || mode_clr) state_n = ST_UNLOCKED;
            default:     state_n = ST_LOCKED;
        endcase
    end

    // State register; power-on and brownout return to locked.
    always_ff @(posedge clk) begin
        if (!rst_n || bor_evt) state_q <= ST_LOCKED;
        else                   state_q <= state_n;
    end

    assign unlocked = (state_q != ST_LOCKED);
    assign dbg_mode = (state_q == ST_DEBUG);
endmodule

// File: rtl/debug_access_ctrl.sv
// Top of the debug access controller. Synchronizes the raw debug pin and
// key strobe, receives the serial key while the reset pin is low, runs
// the access state machine and the STOP-mode reset request.
// Assumes pin_reset_n, stop_mode and event pulses are synchronous to clk.
module debug_access_ctrl #(
    parameter int               KEY_W     = 32,
    parameter logic [KEY_W-1:0] KEY       = 32'h6B2E_91D4,
    parameter int               SYNC_STGS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bor_evt,
    input  logic wdt_evt,
    input  logic pin_reset_n,
    input  logic dbg_pin,
    input  logic key_clk,
    input  logic stop_mode,
    input  logic baud_done,
    input  logic mode_clr,
    output logic unlocked,
    output logic dbg_mode,
    output logic sys_rst_req
);
    logic [1:0] raw_w;
    logic [1:0] sync_w;
    logic       key_ok_w;

    assign raw_w = {key_clk, dbg_pin};

    dbg_sync #(.WIDTH(2), .STAGES(SYNC_STGS), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_w),
        .d_out (sync_w)
    );

    dbg_key_shift #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (bor_evt),
        .arm      (!pin_reset_n),
        .strobe_s (sync_w[1]),
        .data_s   (sync_w[0]),
        .key_ok   (key_ok_w)
    );

    dbg_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bor_evt     (bor_evt),
        .wdt_evt     (wdt_evt),
        .pin_reset_n (pin_reset_n),
        .key_ok      (key_ok_w),
        .baud_done   (baud_done),
        .mode_clr    (mode_clr),
        .unlocked    (unlocked),
        .dbg_mode    (dbg_mode)
    );

    dbg_stop_wake u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_mode (stop_mode),
        .pin_s     (sync_w[0]),
        .req       (sys_rst_req)
    );
endmodule

// File: rtl/debug_access_chk.sv
// Property checker for debug_access_ctrl, attached by bind.
module debug_access_chk (
    input logic clk,
    input logic rst_n,
    input logic bor_evt,
    input logic wdt_evt,
    input logic pin_reset_n,
    input logic stop_mode,
    input logic baud_done,
    input logic mode_clr,
    input logic unlocked,
    input logic dbg_mode,
    input logic sys_rst_req
);
    // R1
    unlock_needs_pin_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> !$past(pin_reset_n));

    // R4
    entry_needs_baud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode) |-> ($past(baud_done) && $past(pin_reset_n)));

    // R5
    sw_clear_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && mode_clr && !bor_evt) |=> (!dbg_mode && unlocked));

    // R6
    reset_source_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && (wdt_evt || !pin_reset_n) && !bor_evt) |=> (!dbg_mode && unlocked));

    // R7
    brownout_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bor_evt |=> (!unlocked && !dbg_mode));

    // R8
    stop_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R8
    stop_req_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(stop_mode));

    // R9
    debug_implies_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> unlocked);
endmodule

bind debug_access_ctrl debug_access_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bor_evt     (bor_evt),
    .wdt_evt     (wdt_evt),
    .pin_reset_n (pin_reset_n),
    .stop_mode   (stop_mode),
    .baud_done   (baud_done),
    .mode_clr    (mode_clr),
    .unlocked    (unlocked),
    .dbg_mode    (dbg_mode),
    .sys_rst_req (sys_rst_req)
);

// File: tb/debug_access_ctrl_bench.sv
`timescale 1ns/1ps
module debug_access_ctrl_bench;
    localparam logic [31:0] TB_KEY = 32'hC35A_1E87;

    logic clk = 1'b0;
    logic rst_n, bor_evt, wdt_evt, pin_reset_n, dbg_pin, key_clk;
    logic stop_mode, baud_done, mode_clr;
    logic unlocked, dbg_mode, sys_rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    debug_access_ctrl #(.KEY_W(32), .KEY(TB_KEY)) u_debug_access_ctrl (
        .clk(clk), .rst_n(rst_n), .bor_evt(bor_evt), .wdt_evt(wdt_evt),
        .pin_reset_n(pin_reset_n), .dbg_pin(dbg_pin), .key_clk(key_clk),
        .stop_mode(stop_mode), .baud_done(baud_done), .mode_clr(mode_clr),
        .unlocked(unlocked), .dbg_mode(dbg_mode), .sys_rst_req(sys_rst_req)
    );

    // Count reset-request pulses away from the active edge.
    always @(negedge clk) if (sys_rst_req === 1'b1) pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            dbg_pin = v[i];
            idle(3);
            key_clk = 1'b1;
            idle(4);
            key_clk = 1'b0;
            idle(3);
        end
        dbg_pin = 1'b1;
        idle(6);
    endtask

    task automatic pulse_baud();
        baud_done = 1'b1;
        idle(1);
        baud_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        chk(unlocked == 0, "R9 reset unlocked", unlocked, 0);
        chk(dbg_mode == 0, "R9 reset dbg_mode", dbg_mode, 0);
        chk(sys_rst_req == 0, "R9 reset sys_rst_req", sys_rst_req, 0);
    endtask

    task automatic t_ignored_strobe();
        pin_reset_n = 1'b1;
        send_bits(TB_KEY, 32);
        chk(unlocked == 0, "R3 key with reset pin high", unlocked, 0);
    endtask

    task automatic t_bad_then_good();
        pin_reset_n = 1'b0;
        idle(2);
        send_bits(TB_KEY ^ 32'h1, 32);
        chk(unlocked == 0, "R2 wrong key stays locked", unlocked, 0);
        send_bits(TB_KEY, 32);
        chk(unlocked == 1, "R1 R2 correct key after mismatch", unlocked, 1);
        pin_reset_n = 1'b1;
        idle(2);
        chk(unlocked == 1, "R1 unlock survives reset release", unlocked, 1);
    endtask

    task automatic t_entry();
        pin_reset_n = 1'b0;
        pulse_baud();
        chk(dbg_mode == 0, "R4 baud with reset pin low", dbg_mode, 0);
        pin_reset_n = 1'b1;
        idle(1);
        pulse_baud();
        chk(dbg_mode == 1, "R4 baud enters debug", dbg_mode, 1);
        chk(unlocked == 1, "R9 debug implies unlocked", unlocked, 1);
    endtask

    task automatic t_exits();
        mode_clr = 1'b1;
        idle(1);
        mode_clr = 1'b0;
        chk(dbg_mode == 0 && unlocked == 1, "R5 software clear", {dbg_mode, unlocked}, 1);
        pulse_baud();
        wdt_evt = 1'b1;
        idle(1);
        wdt_evt = 1'b0;
        chk(dbg_mode == 0 && unlocked == 1, "R6 watchdog exit", {dbg_mode, unlocked}, 1);
        pulse_baud();
        pin_reset_n = 1'b0;
        idle(1);
        chk(dbg_mode == 0, "R6 reset pin exit", dbg_mode, 0);
        pin_reset_n = 1'b1;
        idle(1);
        chk(unlocked == 1, "R6 unlock kept after reset pin", unlocked, 1);
    endtask

    task automatic t_brownout();
        pulse_baud();
        bor_evt = 1'b1;
        idle(1);
        bor_evt = 1'b0;
        chk(unlocked == 0 && dbg_mode == 0, "R7 brownout locks", {dbg_mode, unlocked}, 0);
        pulse_baud();
        idle(1);
        chk(dbg_mode == 0, "R4 baud while locked", dbg_mode, 0);
    endtask

    task automatic t_partial();
        pin_reset_n = 1'b0;
        idle(2);
        send_bits(32'h0000_FFFF, 16);
        pin_reset_n = 1'b1;
        idle(3);
        pin_reset_n = 1'b0;
        idle(2);
        send_bits(TB_KEY, 32);
        chk(unlocked == 1, "R3 partial key discarded", unlocked, 1);
        pin_reset_n = 1'b1;
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        chk(unlocked == 0, "R7 power-on reset locks", unlocked, 0);
    endtask

    task automatic t_stop();
        stop_mode = 1'b1;
        idle(3);
        pulses = 0;
        dbg_pin = 1'b0;
        idle(12);
        chk(pulses == 1, "R8 sustained low one pulse", pulses, 1);
        dbg_pin = 1'b1;
        idle(6);
        pulses = 0;
        dbg_pin = 1'b0;
        idle(1);
        dbg_pin = 1'b1;
        idle(8);
        chk(pulses == 0, "R8 single-sample low", pulses, 0);
        pulses = 0;
        dbg_pin = 1'b0;
        idle(10);
        dbg_pin = 1'b1;
        idle(6);
        chk(pulses == 1, "R8 second episode pulses again", pulses, 1);
        stop_mode = 1'b0;
        idle(2);
        pulses = 0;
        dbg_pin = 1'b0;
        idle(10);
        dbg_pin = 1'b1;
        idle(4);
        chk(pulses == 0, "R8 no pulse outside STOP", pulses, 0);
    endtask

    initial begin
        rst_n = 1'b0; bor_evt = 1'b0; wdt_evt = 1'b0; pin_reset_n = 1'b1;
        dbg_pin = 1'b1; key_clk = 1'b0; stop_mode = 1'b0;
        baud_done = 1'b0; mode_clr = 1'b0;
        t_reset();
        t_ignored_strobe();
        t_bad_then_good();
        t_entry();
        t_exits();
        t_brownout();
        t_partial();
        t_stop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule